// File: doc/BRIEF.md
# Descriptor-Chain Memory Copy Channel

This block is a second-level copy channel that moves data between memory regions by walking a chain of descriptors stored in memory. Software arms it with the address of the first node, a trigger index, a priority, and an acknowledge address and value. From then on it is driven by hardware. A rising edge on the selected one of sixteen transfer-complete lines makes the channel fetch the current node, copy that node's data and write the acknowledge value to the acknowledge address. That write clears the flag of the upstream first-level channel that raised the trigger.

Each node is four 32-bit words: source address, destination address, byte length and next-node pointer. Data moves in whole 128-byte blocks, with source and destination addresses both incrementing. A null next pointer ends the chain. The channel then raises a one-cycle completion interrupt and disarms itself. A chain whose last node points back to an earlier node loops without end, and only software can stop it. A trigger that arrives while a node is in progress is held as pending. A further trigger on top of a pending one sets a sticky error flag.

Top module: `llc_chain_dma`

## Requirements
- R1: After reset the channel is disarmed (`chan_en_o`=0), issues no memory request, and holds `done_irq_o` and `trig_err_o` at 0.
- R2: A `start_i` pulse while disarmed arms the channel and latches the head pointer, the trigger index, the acknowledge address and value, and the priority. `chan_prio_o` shows the priority, where 3 is the highest urgency. No memory request is made until a trigger edge arrives.
- R3: Only a rising edge on `trig_i[trig_sel]` starts a node. Indices 0-7 are the first upstream controller's channels 0-7, and indices 8-15 are the second controller's channels 0-7. Edges on other lines are ignored.
- R4: A node is read as four words at pointer+0, +4, +8 and +12, holding source, destination, byte length and next pointer in that order.
- R5: A node copies ceil(length/128) blocks of 128 bytes, one word at a time, from incrementing source addresses to incrementing destination addresses. A length of 0 copies nothing.
- R6: After its copy, each node performs exactly one write of the latched acknowledge value to the latched acknowledge address. The channel then loads the next pointer and waits for a new trigger edge without issuing requests.
- R7: When the acknowledge write of a node whose next pointer is 0 is accepted, `done_irq_o` pulses for one cycle and `chan_en_o` drops in the same cycle.
- R8: A chain whose next pointer leads back to an earlier node is never disarmed by the hardware. Every further trigger processes the next node of the loop.
- R9: A trigger edge that arrives while a node is being processed is held as pending and starts the following node as soon as the current node's acknowledge write completes.
- R10: A trigger edge that arrives while one is already pending sets `trig_err_o`. The flag stays set until the next accepted start or a stop.
- R11: `stop_i` disarms the channel at once, drops any pending trigger, and causes later trigger edges to be ignored.
- R12: A memory request that is not accepted (`mem_ready_i`=0) stays asserted with the same address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arm pulse; latches configuration when disarmed |
| stop_i | input | 1 | Disarm pulse from software |
| head_ptr_i | input | 32 | Byte address of the first node |
| trig_sel_i | input | 4 | Index of the transfer-complete line used as trigger |
| prio_i | input | 2 | Channel priority (3 = highest) |
| ack_addr_i | input | 32 | Address of the acknowledge write |
| ack_mask_i | input | 32 | Value written as the acknowledge |
| trig_i | input | 16 | Transfer-complete lines from the upstream channels |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata_i | input | 32 | Read data |
| chan_en_o | output | 1 | Channel armed |
| chan_prio_o | output | 2 | Latched priority |
| done_irq_o | output | 1 | One-cycle chain-complete pulse |
| trig_err_o | output | 1 | Sticky trigger overrun flag |

## Verification
The hardest situation to reach is a trigger overrun. It takes a second edge to arrive while one is already pending, both during a single node's copy, and the copy must be long enough to leave room for both. The stimulus builds a self-looping node that moves one full block. It fires the trigger once, then fires it twice more at fixed offsets while that node's word copies are still running. A memory ready line that stalls every third cycle lengthens each node, so the pending case also arises during the short descriptor fetch of a zero-length node.

// File: rtl/llc_pkg.sv
package llc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FETCH,
    ST_RD,
    ST_WR,
    ST_ACK
  } llc_state_e;

  // number of words moved for a node of len_bytes, rounded up to whole blocks
  function automatic logic [31:0] llc_word_count(input logic [31:0] len_bytes,
                                                 input int unsigned blk_bytes);
    logic [31:0] nblk;
    nblk = (len_bytes + 32'(blk_bytes) - 32'd1) / 32'(blk_bytes);
    return nblk * 32'(blk_bytes / 4);
  endfunction

endpackage

// File: rtl/llc_trig_unit.sv
module llc_trig_unit #(
  parameter int N_TRIG = 16,
  localparam int SEL_W = $clog2(N_TRIG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              en_i,
  input  logic              waiting_i,
  input  logic              clear_i,
  output logic              fire_o,
  output logic              err_o
);
  logic line, prev, rise, pending;

  assign line   = trig_i[sel_i];
  assign rise   = line & ~prev;
  assign fire_o = waiting_i & en_i & (rise | pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      pending <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      prev <= line;
      if (clear_i) begin
        pending <= 1'b0;
        err_o   <= 1'b0;
      end else if (waiting_i) begin
        pending <= pending & rise;
      end else if (en_i && rise) begin
        if (pending) err_o <= 1'b1;
        else         pending <= 1'b1;
      end
    end
  end

  // R10: the overrun flag only rises over an already pending trigger
  a_r10_err_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(pending));

  // R9: a pending trigger is kept until the sequencer waits again
  a_r9_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clear_i && !waiting_i) |=> pending);

endmodule

// File: rtl/llc_node_seq.sv
module llc_node_seq
  import llc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int BLK_BYTES = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [AW-1:0] head_i,
  input  logic [AW-1:0] ack_addr_i,
  input  logic [DW-1:0] ack_mask_i,
  input  logic          fire_i,
  output logic          waiting_o,
  output logic          chan_en_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam logic [AW-1:0] WSTEP = AW'(DW / 8);

  llc_state_e    st;
  logic [AW-1:0] cur_ptr, src_q, dst_q, next_q, ack_addr_q;
  logic [DW-1:0] ack_mask_q, buf_q;
  logic [31:0]   words_left;
  logic [1:0]    fidx;
  logic          hs;

  assign hs        = mem_req_o & mem_ready_i;
  assign waiting_o = (st == ST_WAIT);
  assign mem_req_o = (st == ST_FETCH) || (st == ST_RD) || (st == ST_WR) || (st == ST_ACK);
  assign mem_we_o  = (st == ST_WR) || (st == ST_ACK);
  assign mem_wdata_o = (st == ST_ACK) ? ack_mask_q : buf_q;

  always_comb begin
    case (st)
      ST_FETCH: mem_addr_o = cur_ptr + (AW'(fidx) * WSTEP);
      ST_RD:    mem_addr_o = src_q;
      ST_WR:    mem_addr_o = dst_q;
      ST_ACK:   mem_addr_o = ack_addr_q;
      default:  mem_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cur_ptr <= '0; src_q <= '0; dst_q <= '0; next_q <= '0;
      ack_addr_q <= '0; ack_mask_q <= '0; buf_q <= '0;
      words_left <= '0; fidx <= '0;
      chan_en_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (stop_i) begin
        chan_en_o <= 1'b0;
        st        <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: if (start_i) begin
            chan_en_o  <= 1'b1;
            cur_ptr    <= head_i;
            ack_addr_q <= ack_addr_i;
            ack_mask_q <= ack_mask_i;
            st         <= ST_WAIT;
          end
          ST_WAIT: if (fire_i) begin
            fidx <= '0;
            st   <= ST_FETCH;
          end
          ST_FETCH: if (hs) begin
            case (fidx)
              2'd0: src_q <= AW'(mem_rdata_i);
              2'd1: dst_q <= AW'(mem_rdata_i);
              2'd2: words_left <= llc_word_count(32'(mem_rdata_i), BLK_BYTES);
              default: begin
                next_q <= AW'(mem_rdata_i);
                st     <= (words_left == '0) ? ST_ACK : ST_RD;
              end
            endcase
            fidx <= fidx + 2'd1;
          end
          ST_RD: if (hs) begin
            buf_q <= mem_rdata_i;
            st    <= ST_WR;
          end
          ST_WR: if (hs) begin
            src_q      <= src_q + WSTEP;
            dst_q      <= dst_q + WSTEP;
            words_left <= words_left - 32'd1;
            st         <= (words_left == 32'd1) ? ST_ACK : ST_RD;
          end
          ST_ACK: if (hs) begin
            if (next_q == '0) begin
              chan_en_o <= 1'b0;
              done_o    <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              cur_ptr <= next_q;
              st      <= ST_WAIT;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: the completion pulse coincides with the channel being disarmed
  a_r7_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !chan_en_o);

  // R7/R11: disarming only happens through chain end or stop
  a_r11_disarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_en_o) |-> (done_o || $past(stop_i)));

  // R12: a stalled request holds its address
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i && !stop_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R3/R9: a node only begins on a trigger indication
  a_r3_fetch_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH && $past(st) == ST_WAIT) |-> $past(fire_i));

endmodule

// File: rtl/llc_chain_dma.sv
module llc_chain_dma #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int N_TRIG    = 16,
  parameter int BLK_BYTES = 128,
  parameter int PRIO_W    = 2,
  localparam int SEL_W    = $clog2(N_TRIG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [AW-1:0]     head_ptr_i,
  input  logic [SEL_W-1:0]  trig_sel_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [AW-1:0]     ack_addr_i,
  input  logic [DW-1:0]     ack_mask_i,
  input  logic [N_TRIG-1:0] trig_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              chan_en_o,
  output logic [PRIO_W-1:0] chan_prio_o,
  output logic              done_irq_o,
  output logic              trig_err_o
);
  logic [SEL_W-1:0] sel_q;
  logic start_acc, fire, waiting;

  assign start_acc = start_i & ~chan_en_o & ~stop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      chan_prio_o <= '0;
    end else if (start_acc) begin
      sel_q       <= trig_sel_i;
      chan_prio_o <= prio_i;
    end
  end

  llc_trig_unit #(.N_TRIG(N_TRIG)) trig_u (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .sel_i(sel_q),
    .en_i(chan_en_o), .waiting_i(waiting), .clear_i(start_acc | stop_i),
    .fire_o(fire), .err_o(trig_err_o)
  );

  llc_node_seq #(.AW(AW), .DW(DW), .BLK_BYTES(BLK_BYTES)) seq_u (
    .clk(clk), .rst_n(rst_n), .start_i(start_acc), .stop_i(stop_i),
    .head_i(head_ptr_i), .ack_addr_i(ack_addr_i), .ack_mask_i(ack_mask_i),
    .fire_i(fire), .waiting_o(waiting), .chan_en_o(chan_en_o), .done_o(done_irq_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  // R1/R11: no memory traffic while disarmed
  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_o |-> !mem_req_o);

endmodule

// File: tb/llc_chain_dma_tb_top.sv
module llc_chain_dma_tb_top;
  localparam logic [31:0] ACK_A = 32'h0000_0FF0;
  localparam logic [31:0] ACK_M = 32'h0000_0020;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [31:0] head = '0;
  logic [3:0]  tsel = '0;
  logic [1:0]  prio = '0;
  logic [15:0] trig = '0;
  logic mem_req, mem_we, mem_ready, chan_en, done_irq, trig_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] chan_prio;
  logic [1:0] rcnt = '0;
  logic [31:0] mem [0:1023];
  logic [63:0] exp_q[$];
  int checks = 0, errors = 0, irq_cnt = 0;
  logic prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  always #5 clk = ~clk;

  llc_chain_dma dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .head_ptr_i(head),
    .trig_sel_i(tsel), .prio_i(prio), .ack_addr_i(ACK_A), .ack_mask_i(ACK_M),
    .trig_i(trig), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .chan_en_o(chan_en), .chan_prio_o(chan_prio), .done_irq_o(done_irq),
    .trig_err_o(trig_err)
  );

  // memory model: stalls every third cycle, combinational read data
  assign mem_ready = (rcnt != 2'd2);
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    rcnt <= (rcnt == 2'd2) ? 2'd0 : rcnt + 2'd1;
    if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;
  end

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA500_0000 ^ (a * 32'd7);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected writes of one node (R4 R5 R6)
  task automatic push_node(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] len);
    int nw = int'((len + 32'd127) / 32'd128) * 32;
    for (int i = 0; i < nw; i++)
      exp_q.push_back({dst + 32'(4 * i), pat(src + 32'(4 * i))});
    exp_q.push_back({ACK_A, ACK_M});
  endtask

  task automatic put_node(input int p, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] l, input logic [31:0] n);
    mem[p / 4] = s; mem[p / 4 + 1] = d; mem[p / 4 + 2] = l; mem[p / 4 + 3] = n;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); trig[k] = 1'b1;
    @(negedge clk); trig[k] = 1'b0;
  endtask

  task automatic arm(input logic [31:0] h, input logic [3:0] s, input logic [1:0] p);
    @(negedge clk); head = h; tsel = s; prio = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req) seen = 1'b1;
    end
    check(!seen, req, 64'(seen), 64'd0);
  endtask

  // monitor side of the scoreboard, plus the stall-hold check (R12)
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_irq) irq_cnt++;
      if (prev_stall && !stop)
        check(mem_req && mem_addr == prev_addr, "R12", {31'd0, mem_req, mem_addr}, {32'd1, prev_addr});
      prev_stall = mem_req && !mem_ready;
      prev_addr  = mem_addr;
      if (mem_req && mem_we && mem_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 64'd0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check({mem_addr, mem_wdata} == e, "R5/R6 write", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i * 4));
    put_node(32'h100, 32'h400, 32'h800, 32'd4,   32'h110);
    put_node(32'h110, 32'h400, 32'hA00, 32'd0,   32'h120);
    put_node(32'h120, 32'h480, 32'h900, 32'd200, 32'h0);
    put_node(32'h130, 32'h400, 32'hC00, 32'd128, 32'h130);
    repeat (3) @(negedge clk);
    check(!chan_en && !mem_req && !done_irq && !trig_err, "R1",
          {chan_en, mem_req, done_irq, trig_err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!chan_en && !mem_req, "R1 after release", {chan_en, mem_req}, 64'd0);

    arm(32'h100, 4'd5, 2'd3);
    check(chan_en && chan_prio == 2'd3, "R2", {chan_en, chan_prio}, {1'b1, 2'd3});
    quiet(20, "R2 no request before trigger");
    pulse(4);
    pulse(13);
    quiet(20, "R3 other lines ignored");

    push_node(32'h400, 32'h800, 32'd4);
    pulse(5);
    drain();
    check(chan_en && exp_q.size() == 0, "R5 rounded node done", {chan_en}, 64'd1);
    quiet(30, "R6 waits for next trigger");

    push_node(32'h400, 32'hA00, 32'd0);
    push_node(32'h480, 32'h900, 32'd200);
    pulse(5);
    repeat (2) @(negedge clk);
    pulse(5);
    drain();
    check(irq_cnt == 1, "R7 completion pulse", 64'(irq_cnt), 64'd1);
    check(!chan_en, "R7 disarmed", {chan_en}, 64'd0);
    check(!trig_err, "R9 pending without error", {trig_err}, 64'd0);

    arm(32'h130, 4'd9, 2'd1);
    check(chan_prio == 2'd1, "R2 priority", {chan_prio}, 64'd1);
    push_node(32'h400, 32'hC00, 32'd128);
    push_node(32'h400, 32'hC00, 32'd128);
    pulse(9);
    repeat (10) @(negedge clk);
    pulse(9);
    repeat (10) @(negedge clk);
    pulse(9);
    @(negedge clk);
    check(trig_err, "R10 overrun flag", {trig_err}, 64'd1);
    drain();
    check(chan_en && irq_cnt == 1, "R8 loop stays armed", {chan_en, 31'(irq_cnt)}, {1'b1, 31'd1});
    check(trig_err, "R10 flag sticky", {trig_err}, 64'd1);
    push_node(32'h400, 32'hC00, 32'd128);
    pulse(9);
    drain();
    check(chan_en, "R8 loop repeats", {chan_en}, 64'd1);

    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check(!chan_en && !trig_err, "R11 stop", {chan_en, trig_err}, 64'd0);
    pulse(9);
    quiet(20, "R11 triggers ignored after stop");

    arm(32'h130, 4'd9, 2'd2);
    check(chan_en && !trig_err && chan_prio == 2'd2, "R2 rearm", {chan_en, trig_err, chan_prio},
          {1'b1, 1'b0, 2'd2});
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check(exp_q.size() == 0, "R6 all writes seen", 64'(exp_q.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule